// File: doc/BRIEF.md
# Serial Register Front End for a Four-Channel Wiper Controller

This block is the serial control port of a four-channel digital potentiometer controller. A host acts as bus master and drives a mode-0 serial link with a clock, an active-low select, a data input and a data output. The block decodes a one-byte command and the data bytes after it. It stores four 7-bit wiper settings and one 8-bit control byte, and it presents the four wiper settings on a parallel output bus for the resistor ladders. The ladders themselves are not part of the block.

All four link pins are brought into the system clock domain through two-flop synchronisers. The link clock must therefore be several system clocks slow. A write frame is one command byte and one or more data bytes. The update is applied only when the select line returns high. A read frame is four bytes long. The third byte returns the command on the data output and the fourth byte returns the addressed register. A shutdown input parks the wiper outputs and keeps the stored settings. A supply-glitch input that arrives during shutdown returns every wiper to mid-scale.

Frame sequencing is handled by a state machine with these states:
- `S_IDLE`: the select line is high.
- `S_INSTR`: the command byte is being received.
- `S_WDATA`: write data is being received.
- `S_RDUMMY`: the second byte of a read.
- `S_RECHO`: the command is being returned.
- `S_RDATA`: the register contents are being returned.
- `S_SKIP`: the rest of the frame is ignored.

Transitions:
- `S_IDLE` goes to `S_INSTR` when the select line is low.
- At the end of the command byte, a write command goes to `S_WDATA`, a read command goes to `S_RDUMMY`, and any other code goes to `S_SKIP`.
- `S_RDUMMY` goes to `S_RECHO`, then to `S_RDATA`, then to `S_SKIP`, one step at the end of each byte.
- `S_WDATA` stays where it is at the end of each data byte.
- Every state returns to `S_IDLE` when the select line is high.

Top module: `wpr_spi_ctrl`

## Requirements
- R1: After reset, every wiper output reads 40h, the control byte reads 00h and the serial data output is low.
- R2: Serial data is sampled on the rising link clock and sent most significant bit first. The data output changes only after a falling link clock, so the host can sample it on the next rising edge.
- R3: The command byte holds the operation code in bits 7:5 and the register address in bits 4:0. The codes are: 000 no operation, 001 control read, 011 control write, 100 register read, 110 register write.
- R4: With codes 100 and 110, address 0 to 3 selects wiper 0 to 3 and address 10000b selects the control byte. Codes 001 and 011 always reach the control byte, whatever the address bits hold.
- R5: A write is applied only after the select line rises. While the select line is still low, the wiper outputs keep their old values.
- R6: When a write frame carries several complete data bytes, only the last one is stored. A trailing partial byte is dropped. A frame with no complete data byte changes nothing.
- R7: In a read frame, byte three returns the command byte on the data output and byte four returns the register. Bit 7 of a wiper read is 0.
- R8: A write to an undefined address changes nothing, and a read of an undefined address returns 00h. Codes 000, 010, 101 and 111 change nothing and leave the data output low for the whole frame.
- R9: A wiper write keeps only the low 7 bits of the data byte.
- R10: While shutdown is high, all wiper outputs read 0 and the stored settings are kept. Writes are still accepted. When shutdown falls, the outputs show the stored settings.
- R11: A supply-glitch pulse while shutdown is high sets every stored wiper to 40h and leaves the control byte unchanged. The same pulse is ignored when shutdown is low.
- R12: The data output is low while the select line is high. If the select line rises in the middle of a frame, the frame is aborted and the next frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial link clock from the host |
| cs_n | input | 1 | Active-low frame select from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| shutdown | input | 1 | Parks the wiper outputs while high (synchronous to clk) |
| supply_glitch | input | 1 | Supply-glitch pulse (synchronous to clk) |
| wiper_o | output | NCH*WBITS | Wiper settings, channel i in bits [i*WBITS +: WBITS] |

## Verification
The assertions assume that the link clock and the select line change at most once in several system clocks. They also assume that the select line is never toggled within a link clock period, so every synchronised edge appears as a single-cycle pulse. They take the shutdown and glitch inputs to be synchronous to the system clock. The stimulus holds each link clock phase for four system clocks. It changes the data input only on falling link clock edges and gives the select line half a link period of margin on both sides of a frame. The random frames vary only opcodes, addresses, data bytes, byte counts and partial bit counts within that timing.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    localparam int        DEF_NCH   = 4;
    localparam int        DEF_WBITS = 7;
    localparam logic [4:0] CTRL_ADDR = 5'b10000;

    localparam logic [2:0] OPC_NOP     = 3'b000;
    localparam logic [2:0] OPC_CTRL_RD = 3'b001;
    localparam logic [2:0] OPC_CTRL_WR = 3'b011;
    localparam logic [2:0] OPC_REG_RD  = 3'b100;
    localparam logic [2:0] OPC_REG_WR  = 3'b110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INSTR,
        S_WDATA,
        S_RDUMMY,
        S_RECHO,
        S_RDATA,
        S_SKIP
    } st_e;

endpackage

// File: rtl/wpr_sync.sv
module wpr_sync #(
    parameter int         W    = 1,
    parameter logic [0:0] RSTV = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= {W{RSTV}};
            q    <= {W{RSTV}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/wpr_frame.sv
module wpr_frame
    import wpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       cs_s,
    input  logic       sdi_s,
    input  logic [7:0] rd_data,
    output logic [4:0] tgt_addr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sdo,
    output st_e        st
);
    st_e        st_nx;
    logic       sck_q;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr;
    logic [7:0] tx_sr;
    logic [7:0] instr_q;
    logic       pend_valid;
    logic       sck_rise;
    logic       sck_fall;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic [2:0] opc;

    assign sck_rise  = sck_s & ~sck_q;
    assign sck_fall  = ~sck_s & sck_q;
    assign byte_done = sck_rise && !cs_s && (st != S_IDLE) && (bit_cnt == 3'd7);
    assign rx_byte   = {rx_sr[6:0], sdi_s};
    assign opc       = instr_q[7:5];

    // control opcodes reach the control byte whatever the address field holds
    assign tgt_addr  = (opc == OPC_CTRL_RD || opc == OPC_CTRL_WR) ? CTRL_ADDR : instr_q[4:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (cs_s) begin
            st_nx = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:   st_nx = S_INSTR;
                S_INSTR: begin
                    if (byte_done) begin
                        if (rx_byte[7:5] == OPC_REG_WR || rx_byte[7:5] == OPC_CTRL_WR)
                            st_nx = S_WDATA;
                        else if (rx_byte[7:5] == OPC_REG_RD || rx_byte[7:5] == OPC_CTRL_RD)
                            st_nx = S_RDUMMY;
                        else
                            st_nx = S_SKIP;
                    end
                end
                S_WDATA:  st_nx = S_WDATA;
                S_RDUMMY: if (byte_done) st_nx = S_RECHO;
                S_RECHO:  if (byte_done) st_nx = S_RDATA;
                S_RDATA:  if (byte_done) st_nx = S_SKIP;
                S_SKIP:   st_nx = S_SKIP;
                default:  st_nx = S_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            instr_q    <= '0;
            wr_data    <= '0;
            pend_valid <= 1'b0;
            wr_en      <= 1'b0;
            sdo        <= 1'b0;
        end else begin
            sck_q <= sck_s;
            wr_en <= 1'b0;
            if (cs_s) begin
                // frame closed: commit a pending write once, clear the link side
                wr_en      <= (st == S_WDATA) && pend_valid;
                pend_valid <= 1'b0;
                bit_cnt    <= '0;
                rx_sr      <= '0;
                tx_sr      <= '0;
                sdo        <= 1'b0;
            end else if (st != S_IDLE) begin
                if (sck_rise) begin
                    rx_sr   <= rx_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        unique case (st)
                            S_INSTR: instr_q <= rx_byte;
                            S_WDATA: begin
                                wr_data    <= rx_byte;
                                pend_valid <= 1'b1;
                            end
                            S_RDUMMY: tx_sr <= instr_q;
                            S_RECHO:  tx_sr <= rd_data;
                            default:  tx_sr <= '0;
                        endcase
                    end
                end else if (sck_fall) begin
                    sdo   <= tx_sr[7];
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/wpr_regs.sv
module wpr_regs #(
    parameter int NCH   = 4,
    parameter int WBITS = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [4:0]                tgt_addr,
    input  logic [7:0]                wr_data,
    input  logic                      shutdown,
    input  logic                      supply_glitch,
    output logic [7:0]                rd_data,
    output logic [NCH-1:0][WBITS-1:0] stored,
    output logic [NCH*WBITS-1:0]      wiper_o
);
    import wpr_pkg::*;

    localparam logic [WBITS-1:0] MIDV   = WBITS'(1) << (WBITS - 1);
    localparam int               PADW   = 8 - WBITS;

    logic [7:0] ctrl_q;
    logic       reset_mid;

    assign reset_mid = shutdown && supply_glitch;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stored[i] <= MIDV;
            else if (reset_mid)
                stored[i] <= MIDV;
            else if (wr_en && tgt_addr == 5'(i))
                stored[i] <= wr_data[WBITS-1:0];
        end
        assign wiper_o[i*WBITS +: WBITS] = shutdown ? '0 : stored[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= 8'h00;
        else if (wr_en && tgt_addr == CTRL_ADDR)
            ctrl_q <= wr_data;
    end

    always_comb begin
        rd_data = 8'h00;
        if (tgt_addr == CTRL_ADDR)
            rd_data = ctrl_q;
        else
            for (int i = 0; i < NCH; i++)
                if (tgt_addr == 5'(i))
                    rd_data = {{PADW{1'b0}}, stored[i]};
    end
endmodule

// File: rtl/wpr_spi_ctrl.sv
module wpr_spi_ctrl #(
    parameter int NCH   = 4,
    parameter int WBITS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 sdi,
    output logic                 sdo,
    input  logic                 shutdown,
    input  logic                 supply_glitch,
    output logic [NCH*WBITS-1:0] wiper_o
);
    import wpr_pkg::*;

    logic                      sck_s;
    logic                      cs_s;
    logic                      sdi_s;
    logic [7:0]                rd_data;
    logic [4:0]                tgt_addr;
    logic                      wr_en;
    logic [7:0]                wr_data;
    logic [NCH-1:0][WBITS-1:0] stored;
    st_e                       st;

    wpr_sync #(.W(1), .RSTV(1'b0)) u_sync_sck (.clk(clk), .rst_n(rst_n), .d(sck),  .q(sck_s));
    wpr_sync #(.W(1), .RSTV(1'b1)) u_sync_cs  (.clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
    wpr_sync #(.W(1), .RSTV(1'b0)) u_sync_sdi (.clk(clk), .rst_n(rst_n), .d(sdi),  .q(sdi_s));

    wpr_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .cs_s     (cs_s),
        .sdi_s    (sdi_s),
        .rd_data  (rd_data),
        .tgt_addr (tgt_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sdo      (sdo),
        .st       (st)
    );

    wpr_regs #(.NCH(NCH), .WBITS(WBITS)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .tgt_addr      (tgt_addr),
        .wr_data       (wr_data),
        .shutdown      (shutdown),
        .supply_glitch (supply_glitch),
        .rd_data       (rd_data),
        .stored        (stored),
        .wiper_o       (wiper_o)
    );
endmodule

// File: rtl/wpr_spi_ctrl_chk.sv
module wpr_spi_ctrl_chk
    import wpr_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int WBITS = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      shutdown,
    input logic                      supply_glitch,
    input logic                      wr_en,
    input logic                      cs_s,
    input st_e                       st,
    input logic [NCH-1:0][WBITS-1:0] stored,
    input logic [NCH*WBITS-1:0]      wiper_o
);
    localparam logic [WBITS-1:0] MIDV = WBITS'(1) << (WBITS - 1);

    // R5: stored settings move only on a commit pulse or a glitch reset
    a_r5_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(shutdown && supply_glitch)) |=> $stable(stored));

    // R5: one commit pulse per frame close
    a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R10: parked outputs in shutdown
    a_r10_parked: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (wiper_o == '0));

    // R10: outputs follow stored settings when running
    a_r10_running: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown |-> (wiper_o == stored));

    // R11: glitch in shutdown forces mid-scale everywhere
    a_r11_glitch_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && supply_glitch) |=> (stored == {NCH{MIDV}}));

    // R12: a high select returns the sequencer to idle
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st == S_IDLE));
endmodule

bind wpr_spi_ctrl wpr_spi_ctrl_chk #(.NCH(NCH), .WBITS(WBITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .shutdown      (shutdown),
    .supply_glitch (supply_glitch),
    .wr_en         (wr_en),
    .cs_s          (cs_s),
    .st            (st),
    .stored        (stored),
    .wiper_o       (wiper_o)
);

// File: tb/wpr_spi_ctrl_bench.sv
module wpr_spi_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int HALF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic shutdown = 1'b0;
    logic supply_glitch = 1'b0;
    logic sdo;
    logic [27:0] wiper_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [6:0] mw [4];
    logic [7:0] mctrl;

    always #(CLK_P/2) clk = ~clk;

    wpr_spi_ctrl u_wpr_spi_ctrl (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .shutdown(shutdown), .supply_glitch(supply_glitch), .wiper_o(wiper_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] instr);
        logic [2:0] op = instr[7:5];
        logic [4:0] a  = instr[4:0];
        if (op == 3'b001) return mctrl;
        if (op == 3'b100) begin
            if (a < 5'd4)   return {1'b0, mw[a[1:0]]};
            if (a == 5'd16) return mctrl;
            return 8'h00;
        end
        return 8'h00;
    endfunction

    task automatic check_wipers(input string req);
        for (int i = 0; i < 4; i++)
            chk(req, {25'd0, wiper_o[i*7 +: 7]}, shutdown ? 32'd0 : {25'd0, mw[i]}, $sformatf("wiper%0d", i));
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            sdi = tx[7-i];
            waitc(HALF);
            rx[7-i] = sdo;
            sck = 1'b1;
            waitc(HALF);
            sck = 1'b0;
        end
    endtask

    // write frame: command, nfull complete bytes, then partbits of one more byte
    task automatic do_write(input logic [7:0] instr, input logic [3:0][7:0] d,
                            input int nfull, input int partbits, input string req);
        logic [7:0] rx;
        logic [2:0] op = instr[7:5];
        logic [4:0] a  = instr[4:0];
        cs_n = 1'b0;
        waitc(HALF);
        xfer(instr, 8, rx);
        for (int k = 0; k < nfull; k++) xfer(d[k], 8, rx);
        if (partbits > 0) xfer(d[nfull], partbits, rx);
        waitc(HALF);
        check_wipers("R5 before select rises");
        cs_n = 1'b1;
        waitc(8);
        if (nfull > 0) begin
            if (op == 3'b110) begin
                if (a < 5'd4)        mw[a[1:0]] = d[nfull-1][6:0];
                else if (a == 5'd16) mctrl = d[nfull-1];
            end else if (op == 3'b011) begin
                mctrl = d[nfull-1];
            end
        end
        check_wipers(req);
    endtask

    task automatic do_read(input logic [7:0] instr, input string req);
        logic [7:0] r1, r2, echo, dat, expd;
        bit is_rd = (instr[7:5] == 3'b100) || (instr[7:5] == 3'b001);
        cs_n = 1'b0;
        waitc(HALF);
        xfer(instr, 8, r1);
        xfer(8'($urandom), 8, r2);
        xfer(8'h00, 8, echo);
        xfer(8'($urandom), 8, dat);
        waitc(HALF);
        cs_n = 1'b1;
        waitc(8);
        expd = is_rd ? model_read(instr) : 8'h00;
        chk(req, {24'd0, echo}, is_rd ? {24'd0, instr} : 32'd0, "echo byte");
        chk(req, {24'd0, dat}, {24'd0, expd}, "data byte");
        chk("R12", {31'd0, sdo}, 32'd0, "sdo idle");
    endtask

    task automatic pulse_glitch();
        supply_glitch = 1'b1;
        waitc(1);
        supply_glitch = 1'b0;
        if (shutdown) for (int i = 0; i < 4; i++) mw[i] = 7'h40;
        waitc(2);
    endtask

    initial begin
        logic [7:0] rx;
        void'($urandom(32'd24681));
        for (int i = 0; i < 4; i++) mw[i] = 7'h40;
        mctrl = 8'h00;
        waitc(5);
        rst_n = 1'b1;
        waitc(5);

        // R1 reset state
        check_wipers("R1");
        chk("R1", {31'd0, sdo}, 32'd0, "sdo after reset");
        do_read(8'h20, "R1 control reset");

        // R9 / R3 / R7 wiper write and read back
        do_write(8'hC2, {8'h0, 8'h0, 8'h0, 8'h95}, 1, 0, "R9");
        do_read(8'h82, "R7 R2 wiper2 readback");

        // R6 multi-byte write keeps last byte
        do_write(8'hC0, {8'h0, 8'h33, 8'h22, 8'h11}, 3, 0, "R6 last byte");
        do_read(8'h80, "R6 readback");
        // R6 trailing partial byte dropped
        do_write(8'hC1, {8'h0, 8'h0, 8'h7F, 8'h5A}, 1, 5, "R6 partial tail");
        // R6 no complete data byte
        do_write(8'hC3, {8'h0, 8'h0, 8'h0, 8'h12}, 0, 4, "R6 no data");
        do_read(8'h83, "R6 wiper3 untouched");

        // R4 control byte via both routes, address bits ignored for 011/001
        do_write(8'h7A, {8'h0, 8'h0, 8'h0, 8'hA5}, 1, 0, "R4 ctrl write");
        do_read(8'h35, "R4 ctrl read dont-care addr");
        do_read(8'h90, "R4 ctrl via reg read");
        do_write(8'hD0, {8'h0, 8'h0, 8'h0, 8'hC3}, 1, 0, "R4 ctrl via reg write");
        do_read(8'h20, "R3 ctrl read");

        // R8 undefined addresses and opcodes
        do_write(8'hC5, {8'h0, 8'h0, 8'h0, 8'h01}, 1, 0, "R8 undef addr write");
        do_read(8'h89, "R8 undef addr read");
        do_write(8'h01, {8'h0, 8'h0, 8'h0, 8'h02}, 1, 0, "R8 nop write");
        do_write(8'hE1, {8'h0, 8'h0, 8'h0, 8'h03}, 1, 0, "R8 opcode 111");
        do_read(8'h41, "R8 opcode 010 silent");
        do_read(8'h80, "R8 wiper0 intact");

        // R12 abort mid command, then a normal frame
        cs_n = 1'b0;
        waitc(HALF);
        xfer(8'hC0, 4, rx);
        waitc(HALF);
        cs_n = 1'b1;
        waitc(8);
        chk("R12", {31'd0, sdo}, 32'd0, "sdo after abort");
        do_write(8'hC1, {8'h0, 8'h0, 8'h0, 8'h2B}, 1, 0, "R12 frame after abort");

        // R10 shutdown park/restore, writes accepted meanwhile
        shutdown = 1'b1;
        waitc(2);
        check_wipers("R10 parked");
        do_write(8'hC0, {8'h0, 8'h0, 8'h0, 8'h0C}, 1, 0, "R10 write in shutdown");
        shutdown = 1'b0;
        waitc(2);
        check_wipers("R10 restored");

        // R11 glitch ignored when running, mid-scale in shutdown
        pulse_glitch();
        check_wipers("R11 glitch ignored");
        shutdown = 1'b1;
        waitc(2);
        pulse_glitch();
        shutdown = 1'b0;
        waitc(2);
        check_wipers("R11 glitch mid-scale");
        do_read(8'h20, "R11 ctrl kept");

        // random mix
        for (int n = 0; n < 60; n++) begin
            int sel = int'($urandom % 8);
            logic [3:0][7:0] d = {8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)};
            case (sel)
                0, 1, 2: do_write({3'b110, 3'b000, 2'($urandom)}, d, 1 + int'($urandom % 3), 0, "R3 R6 random write");
                3:       do_write({3'b011, 5'($urandom)}, d, 1, 0, "R4 random ctrl write");
                4:       do_read({3'b100, 3'b000, 2'($urandom)}, "R7 random read");
                5:       do_write({3'b110, 5'd4 + 5'($urandom % 12)}, d, 1, 0, "R8 random undef write");
                6:       do_write({3'b110, 3'b000, 2'($urandom)}, d, int'($urandom % 3), 1 + int'($urandom % 7), "R6 random partial");
                default: begin
                    shutdown = ~shutdown;
                    waitc(2);
                    if ($urandom % 2 == 0) pulse_glitch();
                    check_wipers("R10 R11 random");
                end
            endcase
        end
        shutdown = 1'b0;
        waitc(2);
        check_wipers("R10 final");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule